// File: doc/BRIEF.md
# Load/Store Address Offset Generator

This combinational unit forms the effective address of a word or unsigned-byte load or store. It takes a base register value and, depending on the selected offset form, combines it with nothing, with a 12-bit unsigned immediate, with an index register value, or with an index register value that first passes through a barrel shifter. A direction bit chooses whether the offset is added to the base or subtracted from it. The unsigned offset magnitude is also driven out, so that a later stage can reuse it when it updates the base register.

The scaled form shifts the index by a 5-bit amount. It supports logical left, logical right, arithmetic right and rotate right. An amount of zero has special meanings. For logical left it passes the index through unchanged. For the two right shifts it means a full 32-bit shift. For rotate right it selects a one-place rotate through the incoming carry flag. Indexing sequence, write-back, the memory access itself and alignment checks all belong to the surrounding pipeline.

Top module: `ls_addr_gen`

## Requirements
- R1: With form code 1 (immediate), the offset is the 12-bit immediate zero-extended to 32 bits.
- R2: With form code 0 (zero offset), the address equals the base and neither the immediate nor the index has any effect.
- R3: With form code 2 (register), the offset is the index value, unshifted.
- R4: With form code 3 (scaled) and a nonzero amount, shift kind 0 gives index shifted left, 1 shifted right with zero fill, 2 shifted right with sign fill and 3 rotated right, each by the amount.
- R5: With form code 3, kind 3 and amount 0, the offset is the index shifted right by one place with the carry flag in bit 31.
- R6: With form code 3 and amount 0, kind 1 gives an all-zero offset and kind 2 gives 32 copies of index bit 31.
- R7: With form code 3, kind 0 and amount 0, the offset equals the index.
- R8: The address is base plus offset when the direction bit is 1 and base minus offset when it is 0, wrapping modulo 2^32.
- R9: The offset output carries the unsigned offset magnitude before the direction is applied, and is zero in the zero-offset form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| imm_i | input | 12 | Unsigned immediate offset |
| form_i | input | 2 | Offset form: 0 zero, 1 immediate, 2 register, 3 scaled |
| up_i | input | 1 | 1 adds the offset, 0 subtracts it |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_i | input | 5 | Encoded shift amount |
| carry_i | input | 1 | Incoming carry flag, used by the rotate-through-carry case |
| addr_o | output | 32 | Effective address |
| offset_o | output | 32 | Offset magnitude for later write-back |

## Verification
Every form is driven with random base, index and immediate values in both directions, and a behavioural model predicts each result. This separates the four forms from each other and shows that the add and subtract paths are not swapped. The scaled form is swept over all four kinds and all 32 amount codes, with index values that have bit 31 both set and clear and with the carry flag at both levels. That sweep separates sign fill from zero fill, and it separates the amount-zero special cases from ordinary shifts. Directed cases push the adder across the 2^32 wrap in both directions. They also feed a nonzero immediate and index in the zero form, to show that neither reaches the address.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned IMM_W   = 12;
    localparam int unsigned SHAMT_W = $clog2(ADDR_W);

    typedef enum logic [1:0] {
        OFS_ZERO   = 2'd0,
        OFS_IMM    = 2'd1,
        OFS_REG    = 2'd2,
        OFS_SCALED = 2'd3
    } ofs_form_e;

    typedef enum logic [1:0] {
        SHF_LSL = 2'd0,
        SHF_LSR = 2'd1,
        SHF_ASR = 2'd2,
        SHF_ROR = 2'd3
    } shf_kind_e;

    // Control decoded once for the barrel stages.
    typedef struct packed {
        logic to_left;
        logic rotate;
        logic fill;
    } shf_ctrl_t;

endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
    import lsag_pkg::*;
#(
    parameter int unsigned XLEN = ADDR_W,
    localparam int unsigned AW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] data_i,
    input  shf_kind_e       kind_i,
    input  logic [AW-1:0]   amt_i,
    input  logic            carry_i,
    output logic [XLEN-1:0] data_o
);

    shf_ctrl_t       ctrl;
    logic [XLEN-1:0] din_rev;
    logic [XLEN-1:0] dout_rev;
    logic [XLEN-1:0] stg [AW+1];
    logic [XLEN-1:0] barrel;
    logic [XLEN-1:0] amt_zero_val;

    always_comb begin
        ctrl.to_left = (kind_i == SHF_LSL);
        ctrl.rotate  = (kind_i == SHF_ROR);
        ctrl.fill    = (kind_i == SHF_ASR) ? data_i[XLEN-1] : 1'b0;
    end

    // Left shifts reuse the right-shift stages on bit-reversed data.
    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign din_rev[i]  = data_i[XLEN-1-i];
        assign dout_rev[i] = stg[AW][XLEN-1-i];
    end

    assign stg[0] = ctrl.to_left ? din_rev : data_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned S = 1 << k;
        logic [S-1:0] upper;
        assign upper      = ctrl.rotate ? stg[k][S-1:0] : {S{ctrl.fill}};
        assign stg[k+1]   = amt_i[k] ? {upper, stg[k][XLEN-1:S]} : stg[k];
    end

    assign barrel = ctrl.to_left ? dout_rev : stg[AW];

    // An encoded amount of zero has its own meaning for each kind.
    always_comb begin
        unique case (kind_i)
            SHF_LSL: amt_zero_val = data_i;
            SHF_LSR: amt_zero_val = '0;
            SHF_ASR: amt_zero_val = {XLEN{data_i[XLEN-1]}};
            default: amt_zero_val = {carry_i, data_i[XLEN-1:1]};
        endcase
    end

    assign data_o = (amt_i == '0) ? amt_zero_val : barrel;

endmodule

// File: rtl/lsag_offset_mux.sv
module lsag_offset_mux
    import lsag_pkg::*;
#(
    parameter int unsigned XLEN  = ADDR_W,
    parameter int unsigned IMM_N = IMM_W
) (
    input  ofs_form_e        form_i,
    input  logic [IMM_N-1:0] imm_i,
    input  logic [XLEN-1:0]  index_i,
    input  logic [XLEN-1:0]  scaled_i,
    output logic [XLEN-1:0]  offset_o
);

    localparam int unsigned PAD = XLEN - IMM_N;

    always_comb begin
        unique case (form_i)
            OFS_ZERO: offset_o = '0;
            OFS_IMM:  offset_o = {{PAD{1'b0}}, imm_i};
            OFS_REG:  offset_o = index_i;
            default:  offset_o = scaled_i;
        endcase
    end

endmodule

// File: rtl/lsag_addr_unit.sv
module lsag_addr_unit #(
    parameter int unsigned XLEN = lsag_pkg::ADDR_W
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] offset_i,
    input  logic            up_i,
    output logic [XLEN-1:0] addr_o
);

    logic [XLEN-1:0] operand;
    logic [XLEN:0]   sum;

    // Subtraction as base + ~offset + 1 keeps a single carry chain.
    assign operand = up_i ? offset_i : ~offset_i;
    assign sum     = {1'b0, base_i} + {1'b0, operand} + {{XLEN{1'b0}}, ~up_i};
    assign addr_o  = sum[XLEN-1:0];

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
    import lsag_pkg::*;
#(
    parameter int unsigned XLEN  = ADDR_W,
    parameter int unsigned IMM_N = IMM_W,
    localparam int unsigned AW   = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [XLEN-1:0]  index_i,
    input  logic [IMM_N-1:0] imm_i,
    input  logic [1:0]       form_i,
    input  logic             up_i,
    input  logic [1:0]       kind_i,
    input  logic [AW-1:0]    amt_i,
    input  logic             carry_i,
    output logic [XLEN-1:0]  addr_o,
    output logic [XLEN-1:0]  offset_o
);

    ofs_form_e       form;
    shf_kind_e       kind;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] offset;

    assign form = ofs_form_e'(form_i);
    assign kind = shf_kind_e'(kind_i);

    lsag_shifter #(.XLEN(XLEN)) u_shifter (
        .data_i  (index_i),
        .kind_i  (kind),
        .amt_i   (amt_i),
        .carry_i (carry_i),
        .data_o  (scaled)
    );

    lsag_offset_mux #(.XLEN(XLEN), .IMM_N(IMM_N)) u_offset_mux (
        .form_i   (form),
        .imm_i    (imm_i),
        .index_i  (index_i),
        .scaled_i (scaled),
        .offset_o (offset)
    );

    lsag_addr_unit #(.XLEN(XLEN)) u_addr_unit (
        .base_i   (base_i),
        .offset_i (offset),
        .up_i     (up_i),
        .addr_o   (addr_o)
    );

    assign offset_o = offset;

endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_N = 12,
    localparam int unsigned AW   = $clog2(XLEN)
) (
    input logic [XLEN-1:0]  base_i,
    input logic [XLEN-1:0]  index_i,
    input logic [IMM_N-1:0] imm_i,
    input logic [1:0]       form_i,
    input logic             up_i,
    input logic [1:0]       kind_i,
    input logic [AW-1:0]    amt_i,
    input logic             carry_i,
    input logic [XLEN-1:0]  addr_o,
    input logic [XLEN-1:0]  offset_o
);

    logic known;
    logic scaled_z;

    assign known = !$isunknown({base_i, index_i, imm_i, form_i, up_i,
                                kind_i, amt_i, carry_i});
    assign scaled_z = (form_i == 2'd3) && (amt_i == '0);

    always_comb begin
        if (known) begin
            p_zero_form_r2: assert (form_i != 2'd0 || (addr_o == base_i && offset_o == '0))
                else $error("zero form altered the address");
            p_imm_zext_r1: assert (form_i != 2'd1 || offset_o == XLEN'(imm_i))
                else $error("immediate offset not zero-extended");
            p_reg_pass_r3: assert (form_i != 2'd2 || offset_o == index_i)
                else $error("register offset altered");
            p_lsl_r4: assert (!(form_i == 2'd3 && kind_i == 2'd0 && amt_i != '0)
                              || offset_o == (index_i << amt_i))
                else $error("left shift offset wrong");
            p_rrx_r5: assert (!(scaled_z && kind_i == 2'd3)
                              || offset_o == {carry_i, index_i[XLEN-1:1]})
                else $error("rotate through carry wrong");
            p_lsr32_r6: assert (!(scaled_z && kind_i == 2'd1) || offset_o == '0)
                else $error("logical right by full width not zero");
            p_asr32_r6: assert (!(scaled_z && kind_i == 2'd2)
                                || offset_o == {XLEN{index_i[XLEN-1]}})
                else $error("arithmetic right by full width not sign");
            p_lsl0_r7: assert (!(scaled_z && kind_i == 2'd0) || offset_o == index_i)
                else $error("left shift by zero altered index");
            p_direction_r8: assert ((up_i && addr_o == base_i + offset_o)
                                    || (!up_i && addr_o == base_i - offset_o))
                else $error("address does not match offset and direction");
        end
    end

endmodule

bind ls_addr_gen lsag_checker #(.XLEN(XLEN), .IMM_N(IMM_N)) u_lsag_checker (
    .base_i   (base_i),
    .index_i  (index_i),
    .imm_i    (imm_i),
    .form_i   (form_i),
    .up_i     (up_i),
    .kind_i   (kind_i),
    .amt_i    (amt_i),
    .carry_i  (carry_i),
    .addr_o   (addr_o),
    .offset_o (offset_o)
);

// File: tb/ls_addr_gen_bench.sv
module ls_addr_gen_bench;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] offset;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_i  = '0;
    logic [31:0] index_i = '0;
    logic [11:0] imm_i   = '0;
    logic [1:0]  form_i  = '0;
    logic        up_i    = 1'b1;
    logic [1:0]  kind_i  = '0;
    logic [4:0]  amt_i   = '0;
    logic        carry_i = 1'b0;
    logic [31:0] addr_o;
    logic [31:0] offset_o;

    exp_t queue_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   driver_done = 1'b0;
    bit   reported    = 1'b0;
    int   cycles = 0;

    always #2.5 clk = ~clk;

    ls_addr_gen u_ls_addr_gen (
        .base_i   (base_i),
        .index_i  (index_i),
        .imm_i    (imm_i),
        .form_i   (form_i),
        .up_i     (up_i),
        .kind_i   (kind_i),
        .amt_i    (amt_i),
        .carry_i  (carry_i),
        .addr_o   (addr_o),
        .offset_o (offset_o)
    );

    function automatic logic [31:0] ref_shift(input logic [31:0] x, input logic [1:0] k,
                                              input logic [4:0] a, input logic c);
        int n;
        n = int'(a);
        case (k)
            2'd0: return x << n;
            2'd1: return (n == 0) ? 32'd0 : (x >> n);
            2'd2: return (n == 0) ? {32{x[31]}} : 32'($signed(x) >>> n);
            default: return (n == 0) ? {c, x[31:1]} : ((x >> n) | (x << (32 - n)));
        endcase
    endfunction

    function automatic string pick_tag(input logic [1:0] f, input logic [1:0] k,
                                       input logic [4:0] a);
        if (f == 2'd0) return "R2 R9";
        if (f == 2'd1) return "R1 R8";
        if (f == 2'd2) return "R3 R8";
        if (a != 5'd0) return "R4";
        if (k == 2'd3) return "R5";
        if (k == 2'd0) return "R7";
        return "R6";
    endfunction

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic drive(input logic [31:0] b, input logic [31:0] x, input logic [11:0] im,
                         input logic [1:0] f, input logic u, input logic [1:0] k,
                         input logic [4:0] a, input logic c, input string tag_ovr);
        exp_t e;
        logic [31:0] off;
        @(negedge clk);
        base_i = b; index_i = x; imm_i = im; form_i = f;
        up_i = u; kind_i = k; amt_i = a; carry_i = c;
        case (f)
            2'd0: off = 32'd0;
            2'd1: off = {20'd0, im};
            2'd2: off = x;
            default: off = ref_shift(x, k, a, c);
        endcase
        e.offset = off;
        e.addr   = u ? (b + off) : (b - off);
        e.tag    = (tag_ovr != "") ? tag_ovr : pick_tag(f, k, a);
        queue_q.push_back(e);
    endtask

    // Monitor: compares at the rising edge, half a period after the drive.
    always @(posedge clk) begin
        if (queue_q.size() > 0) begin
            exp_t e;
            e = queue_q.pop_front();
            n_cmp++;
            if (addr_o !== e.addr) begin
                n_bad++;
                $display("FAIL %s addr actual=%h expected=%h", e.tag, addr_o, e.addr);
            end
            n_cmp++;
            if (offset_o !== e.offset) begin
                n_bad++;
                $display("FAIL %s R9 offset actual=%h expected=%h", e.tag, offset_o, e.offset);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-time idle inputs: all zero in zero form.
        drive(32'd0, 32'd0, 12'd0, 2'd0, 1'b1, 2'd0, 5'd0, 1'b0, "R2 reset");
        // R2: immediate and index ignored in zero form, both directions.
        drive(32'h1234_5678, 32'hFFFF_FFFF, 12'hFFF, 2'd0, 1'b0, 2'd3, 5'd7, 1'b1, "R2 R9 ignore");
        drive(32'h8000_0000, 32'h0000_0001, 12'h001, 2'd0, 1'b1, 2'd1, 5'd0, 1'b0, "R2 R9 ignore");
        // R8: wrap across 2^32.
        drive(32'h0000_0000, 32'h0, 12'h001, 2'd1, 1'b0, 2'd0, 5'd0, 1'b0, "R8 underflow");
        drive(32'hFFFF_FFFF, 32'h0, 12'h001, 2'd1, 1'b1, 2'd0, 5'd0, 1'b0, "R8 overflow");
        drive(32'hFFFF_F000, 32'h0, 12'hFFF, 2'd1, 1'b1, 2'd0, 5'd0, 1'b0, "R1 max imm");
        drive(32'h0000_0010, 32'h0000_0020, 12'h0, 2'd2, 1'b0, 2'd0, 5'd0, 1'b0, "R3 R8 negative");
        // R5: both carry levels, R6: both sign levels.
        drive(32'h100, 32'h0000_0003, 12'h0, 2'd3, 1'b1, 2'd3, 5'd0, 1'b1, "R5 carry in");
        drive(32'h100, 32'hFFFF_FFFE, 12'h0, 2'd3, 1'b1, 2'd3, 5'd0, 1'b0, "R5 carry clear");
        drive(32'h100, 32'h8000_0001, 12'h0, 2'd3, 1'b1, 2'd2, 5'd0, 1'b0, "R6 sign set");
        drive(32'h100, 32'h7FFF_FFFF, 12'h0, 2'd3, 1'b1, 2'd2, 5'd0, 1'b0, "R6 sign clear");
        drive(32'h100, 32'hFFFF_FFFF, 12'h0, 2'd3, 1'b0, 2'd1, 5'd0, 1'b0, "R6 lsr full");
        // Random operands in each form, both directions.
        for (int i = 0; i < 40; i++) begin
            for (int f = 0; f < 3; f++) begin
                drive($urandom, $urandom, 12'($urandom), 2'(f), 1'($urandom),
                      2'($urandom), 5'($urandom), 1'($urandom), "");
            end
        end
        // Full sweep of scaled form: every kind and amount, sign and carry varied.
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 32; a++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [31:0] x;
                    x = $urandom;
                    x[31] = s[0];
                    drive($urandom, x, 12'($urandom), 2'd3, 1'($urandom),
                          2'(k), 5'(a), s[1], "");
                end
            end
        end
        driver_done = 1'b1;
        while (queue_q.size() > 0) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule